// File: doc/BRIEF.md
# Bytecode Stack Machine Executor

This block runs short programs written in a byte-oriented, stack-based integer code. A program counter walks a byte-wide code memory. Each opcode byte is fetched and decoded. A push-immediate opcode also fetches one more byte as its operand. The instruction then acts on an eight-entry operand stack of 32-bit words and on a small array of 32-bit local variables.

The instructions cover four groups:
- pushing a sign-extended byte or the constant zero;
- moving values between the stack and local slots 1 to 3;
- adding the two topmost words;
- returning.

A host loads the code memory, pulses `start` and waits for `done`. It then reads any local slot through a combinational debug port. Two sticky flags report why execution stopped early: a stack fault or an opcode outside the supported set.

Top module: `bcx_core`

## Requirements
- R1: Opcode 0x10 takes the following code byte as its operand, sign-extends it from 8 to 32 bits and pushes it; the program counter advances by 2 for this instruction.
- R2: Opcode 0x03 pushes the value 0.
- R3: Opcodes 0x3c, 0x3d and 0x3e pop the top of the stack into local slot 1, 2 and 3 respectively.
- R4: Opcodes 0x1b, 0x1c and 0x1d push the contents of local slot 1, 2 and 3 respectively.
- R5: Opcode 0x60 pops two words and pushes their sum modulo 2^32.
- R6: Opcode 0xb1 stops execution. `done` goes high and stays high, with `code_addr` frozen, until the next `start`. A `start` accepted while idle or done clears every local slot, the stack and both flags, and restarts at address 0.
- R7: The stack holds 8 words. Three cases are stack faults: a push onto a full stack, a pop from an empty stack, and an add with fewer than two words. A stack fault sets `err_stack`, stops execution with `done` high and leaves the locals and the stack unmodified.
- R8: Any opcode not listed in R1 to R6 (for example 0x1a or 0x00) sets `err_opcode` and stops execution with `done` high. The two flags are never high together.
- R9: Each instruction takes one fetch cycle, one operand cycle for 0x10 only, and one execute cycle. For the 13-byte sample program (push 15, store 1, push 9, store 2, push zero, store 3, load 1, load 2, add, store 3, return), `done` is high after the 25th rising edge, counting the edge that samples `start` as the first.
- R10: After a synchronous reset, `done`, `err_stack` and `err_opcode` are 0, `code_addr` is 0 and all local slots read 0.
- R11: `dbg_data` shows local slot `dbg_idx` in the same cycle. The sample program leaves 15, 9 and 24 in slots 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 0 (accepted when idle or done) |
| code_addr | output | CODE_AW | Code memory byte address (the program counter) |
| code_data | input | 8 | Code byte at `code_addr`, valid in the same cycle |
| done | output | 1 | Execution has stopped |
| err_stack | output | 1 | Sticky stack overflow or underflow flag |
| err_opcode | output | 1 | Sticky unsupported-opcode flag |
| dbg_idx | input | clog2(N_LOCALS) | Local slot selected for debug read |
| dbg_data | output | 32 | Contents of the selected local slot |

## Verification
The bench targets these corner cases, each with the failure it would expose:

| Corner case | A faulty design would |
|---|---|
| Negative immediate | Zero-extend it and produce a large positive sum instead of -5. |
| Stack exactly full (8 pushes) | Fault one entry too early. |
| Ninth push | Miss the fault or wrap the stack pointer silently. |
| Store or add on a short stack | Write garbage into a local. |
| Unsupported opcode sitting next to the load opcodes | Decode 0x1a as a load. |
| Restart after an error | Keep a stale flag or stale local value. |

An off-by-one in operand fetch or in the stage count shows up as a wrong cycle count for the sample program.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

    localparam int WORD_W = 32;

    localparam logic [7:0] OP_PUSH_BYTE = 8'h10;
    localparam logic [7:0] OP_PUSH_ZERO = 8'h03;
    localparam logic [7:0] OP_LOAD_L1   = 8'h1b;
    localparam logic [7:0] OP_LOAD_L2   = 8'h1c;
    localparam logic [7:0] OP_LOAD_L3   = 8'h1d;
    localparam logic [7:0] OP_STORE_L1  = 8'h3c;
    localparam logic [7:0] OP_STORE_L2  = 8'h3d;
    localparam logic [7:0] OP_STORE_L3  = 8'h3e;
    localparam logic [7:0] OP_ADD       = 8'h60;
    localparam logic [7:0] OP_RETURN    = 8'hb1;

    typedef enum logic [2:0] {
        K_PUSH_IMM,
        K_PUSH_ZERO,
        K_LOAD,
        K_STORE,
        K_ADD,
        K_RETURN,
        K_ILLEGAL
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [1:0] slot;
    } decoded_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_OPERAND,
        S_EXEC,
        S_DONE
    } state_e;

    typedef enum logic [1:0] {
        STK_NONE,
        STK_PUSH,
        STK_POP,
        STK_REPLACE2
    } stk_op_e;

    function automatic decoded_t decode(input logic [7:0] op);
        decoded_t d;
        d.kind = K_ILLEGAL;
        d.slot = 2'd0;
        case (op)
            OP_PUSH_BYTE: d.kind = K_PUSH_IMM;
            OP_PUSH_ZERO: d.kind = K_PUSH_ZERO;
            OP_LOAD_L1:   begin d.kind = K_LOAD;  d.slot = 2'd1; end
            OP_LOAD_L2:   begin d.kind = K_LOAD;  d.slot = 2'd2; end
            OP_LOAD_L3:   begin d.kind = K_LOAD;  d.slot = 2'd3; end
            OP_STORE_L1:  begin d.kind = K_STORE; d.slot = 2'd1; end
            OP_STORE_L2:  begin d.kind = K_STORE; d.slot = 2'd2; end
            OP_STORE_L3:  begin d.kind = K_STORE; d.slot = 2'd3; end
            OP_ADD:       d.kind = K_ADD;
            OP_RETURN:    d.kind = K_RETURN;
            default:      d.kind = K_ILLEGAL;
        endcase
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] sext8(input logic [7:0] b);
        return {{(WORD_W-8){b[7]}}, b};
    endfunction

endpackage

// File: rtl/bcx_decode.sv
module bcx_decode
    import bcx_pkg::*;
(
    input  logic [7:0] opcode,
    output decoded_t   dec
);

    assign dec = decode(opcode);

endmodule

// File: rtl/bcx_opstack.sv
module bcx_opstack
    import bcx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  stk_op_e                      op,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 top,
    output logic [W-1:0]                 next,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         fault
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  cells [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_free, idx_top, idx_next;

    assign idx_free = IW'(cnt_q);
    assign idx_top  = IW'(cnt_q - CW'(1));
    assign idx_next = IW'(cnt_q - CW'(2));

    always_comb begin
        case (op)
            STK_PUSH:     fault = (cnt_q == CW'(DEPTH));
            STK_POP:      fault = (cnt_q == '0);
            STK_REPLACE2: fault = (cnt_q < CW'(2));
            default:      fault = 1'b0;
        endcase
    end

    assign top   = (cnt_q != '0)     ? cells[idx_top]  : '0;
    assign next  = (cnt_q > CW'(1))  ? cells[idx_next] : '0;
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (!fault) begin
            case (op)
                STK_PUSH:     cnt_q <= cnt_q + CW'(1);
                STK_POP:      cnt_q <= cnt_q - CW'(1);
                STK_REPLACE2: cnt_q <= cnt_q - CW'(1);
                default:      cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!fault) begin
            case (op)
                STK_PUSH:     cells[idx_free] <= wdata;
                STK_REPLACE2: cells[idx_next] <= wdata;
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/bcx_locals.sv
module bcx_locals #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         we,
    input  logic [$clog2(N)-1:0]         widx,
    input  logic [W-1:0]                 wdata,
    input  logic [$clog2(N)-1:0]         ridx,
    output logic [W-1:0]                 rdata,
    input  logic [$clog2(N)-1:0]         dbg_idx,
    output logic [W-1:0]                 dbg_data
);

    localparam int IW = $clog2(N);

    logic [W-1:0] slot_v [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                q <= '0;
            end else if (we && widx == IW'(g)) begin
                q <= wdata;
            end
        end
        assign slot_v[g] = q;
    end

    assign rdata    = slot_v[ridx];
    assign dbg_data = slot_v[dbg_idx];

endmodule

// File: rtl/bcx_core.sv
module bcx_core
    import bcx_pkg::*;
#(
    parameter int CODE_AW   = 8,
    parameter int STK_DEPTH = 8,
    parameter int N_LOCALS  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    output logic [CODE_AW-1:0]           code_addr,
    input  logic [7:0]                   code_data,
    output logic                         done,
    output logic                         err_stack,
    output logic                         err_opcode,
    input  logic [$clog2(N_LOCALS)-1:0]  dbg_idx,
    output logic [WORD_W-1:0]            dbg_data
);

    localparam int LIW = $clog2(N_LOCALS);
    localparam int SCW = $clog2(STK_DEPTH + 1);

    state_e               state_q;
    logic [CODE_AW-1:0]   pc_q;
    decoded_t             dec_q;
    decoded_t             fetch_dec;
    logic [7:0]           imm_q;
    logic                 err_stack_q, err_opcode_q;

    logic                 launch;
    stk_op_e              stk_op;
    logic [WORD_W-1:0]    stk_wdata, stk_top, stk_next;
    logic [SCW-1:0]       stk_cnt;
    logic                 stk_fault;

    logic                 loc_we;
    logic [WORD_W-1:0]    loc_rdata;

    assign launch = start && (state_q == S_IDLE || state_q == S_DONE);

    bcx_decode u_dec (
        .opcode (code_data),
        .dec    (fetch_dec)
    );

    bcx_opstack #(.DEPTH(STK_DEPTH), .W(WORD_W)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .clear (launch),
        .op    (stk_op),
        .wdata (stk_wdata),
        .top   (stk_top),
        .next  (stk_next),
        .count (stk_cnt),
        .fault (stk_fault)
    );

    bcx_locals #(.N(N_LOCALS), .W(WORD_W)) u_locals (
        .clk      (clk),
        .rst      (rst),
        .clear    (launch),
        .we       (loc_we),
        .widx     (LIW'(dec_q.slot)),
        .wdata    (stk_top),
        .ridx     (LIW'(dec_q.slot)),
        .rdata    (loc_rdata),
        .dbg_idx  (dbg_idx),
        .dbg_data (dbg_data)
    );

    always_comb begin
        stk_op    = STK_NONE;
        stk_wdata = '0;
        loc_we    = 1'b0;
        if (state_q == S_EXEC) begin
            case (dec_q.kind)
                K_PUSH_IMM: begin
                    stk_op    = STK_PUSH;
                    stk_wdata = sext8(imm_q);
                end
                K_PUSH_ZERO: begin
                    stk_op    = STK_PUSH;
                    stk_wdata = '0;
                end
                K_LOAD: begin
                    stk_op    = STK_PUSH;
                    stk_wdata = loc_rdata;
                end
                K_STORE: begin
                    stk_op = STK_POP;
                    loc_we = !stk_fault;
                end
                K_ADD: begin
                    stk_op    = STK_REPLACE2;
                    stk_wdata = stk_top + stk_next;
                end
                default: stk_op = STK_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            pc_q         <= '0;
            dec_q        <= '{kind: K_RETURN, slot: 2'd0};
            imm_q        <= '0;
            err_stack_q  <= 1'b0;
            err_opcode_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE, S_DONE: begin
                    if (launch) begin
                        pc_q         <= '0;
                        err_stack_q  <= 1'b0;
                        err_opcode_q <= 1'b0;
                        state_q      <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    dec_q   <= fetch_dec;
                    pc_q    <= pc_q + CODE_AW'(1);
                    state_q <= (fetch_dec.kind == K_PUSH_IMM) ? S_OPERAND : S_EXEC;
                end
                S_OPERAND: begin
                    imm_q   <= code_data;
                    pc_q    <= pc_q + CODE_AW'(1);
                    state_q <= S_EXEC;
                end
                S_EXEC: begin
                    if (dec_q.kind == K_ILLEGAL) begin
                        err_opcode_q <= 1'b1;
                        state_q      <= S_DONE;
                    end else if (stk_fault) begin
                        err_stack_q <= 1'b1;
                        state_q     <= S_DONE;
                    end else if (dec_q.kind == K_RETURN) begin
                        state_q <= S_DONE;
                    end else begin
                        state_q <= S_FETCH;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign code_addr  = pc_q;
    assign done       = (state_q == S_DONE);
    assign err_stack  = err_stack_q;
    assign err_opcode = err_opcode_q;

endmodule

// File: rtl/bcx_core_chk.sv
module bcx_core_chk #(
    parameter int AW    = 8,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic          err_stack,
    input logic          err_opcode,
    input logic [AW-1:0] code_addr,
    input logic [CW-1:0] stk_cnt
);

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!done && !err_stack && !err_opcode && code_addr == '0));

    assert_stack_bound_R7: assert property (@(posedge clk) disable iff (rst)
        stk_cnt <= CW'(DEPTH));

    assert_error_halts_R7: assert property (@(posedge clk) disable iff (rst)
        (err_stack || err_opcode) |-> done);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err_stack && !start) |=> err_stack);

    assert_single_cause_R8: assert property (@(posedge clk) disable iff (rst)
        !(err_stack && err_opcode));

    assert_done_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(code_addr)));

endmodule

bind bcx_core bcx_core_chk #(
    .AW    (CODE_AW),
    .DEPTH (STK_DEPTH),
    .CW    ($clog2(STK_DEPTH + 1))
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .err_stack  (err_stack),
    .err_opcode (err_opcode),
    .code_addr  (code_addr),
    .stk_cnt    (stk_cnt)
);

// File: tb/test_bcx_core.sv
module test_bcx_core;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  code_addr;
    logic [7:0]  code_data;
    logic        done, err_stack, err_opcode;
    logic [1:0]  dbg_idx;
    logic [31:0] dbg_data;

    logic [7:0]  mem [256];

    always #4 clk = ~clk;

    assign code_data = mem[code_addr];

    bcx_core i_bcx_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .code_addr  (code_addr),
        .code_data  (code_data),
        .done       (done),
        .err_stack  (err_stack),
        .err_opcode (err_opcode),
        .dbg_idx    (dbg_idx),
        .dbg_data   (dbg_data)
    );

    typedef struct packed {
        logic [0:15][7:0] prog;
        logic [31:0]      exp_l3;
        logic             exp_stk;
        logic             exp_op;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        // R1 R2 R3 R4 R5: sample program, slot 3 = 24
        '{128'h100f3c10093d033e1b1c603eb1000000, 32'd24, 1'b0, 1'b0},
        // R1 R5: -10 + 5 = -5 (sign extension)
        '{128'h10f61005603eb1000000000000000000, 32'hfffffffb, 1'b0, 1'b0},
        // R4: load slot 3 twice, add -> 14
        '{128'h10073e1d1d603eb10000000000000000, 32'd14, 1'b0, 1'b0},
        // R7: store on empty stack
        '{128'h3eb10000000000000000000000000000, 32'd0, 1'b1, 1'b0},
        // R8: 0x1a unsupported after slot 3 = 5
        '{128'h10053e1ab10000000000000000000000, 32'd5, 1'b0, 1'b1},
        // R7: add with one word
        '{128'h0360b100000000000000000000000000, 32'd0, 1'b1, 1'b0},
        // R7: ninth push overflows
        '{128'h030303030303030303b1000000000000, 32'd0, 1'b1, 1'b0},
        // R7: exactly eight pushes are fine
        '{128'h03030303030303033eb1000000000000, 32'd0, 1'b0, 1'b0}
    };

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load_prog(input logic [0:15][7:0] p);
        for (int i = 0; i < 256; i++) mem[i] = (i < 16) ? p[i] : 8'h00;
    endtask

    task automatic run(output int edges);
        @(negedge clk);
        start = 1'b1;
        edges = 0;
        do begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0;
        end while (!done && edges < 2000);
    endtask

    task automatic peek(input logic [1:0] idx, output logic [31:0] val);
        dbg_idx = idx;
        #1;
        val = dbg_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int          edges;
        logic [31:0] v;
        rst     = 1'b1;
        start   = 1'b0;
        dbg_idx = 2'd0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        check("R10", "done", {31'd0, done}, 32'd0);
        check("R10", "err_stack", {31'd0, err_stack}, 32'd0);
        check("R10", "err_opcode", {31'd0, err_opcode}, 32'd0);
        check("R10", "code_addr", {24'd0, code_addr}, 32'd0);
        for (int s = 0; s < 4; s++) begin
            peek(2'(s), v);
            check("R10", "local after reset", v, 32'd0);
        end

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            load_prog(VECS[k].prog);
            run(edges);
            $display("vector %0d", k);
            check("R6", "done", {31'd0, done}, 32'd1);
            peek(2'd3, v);
            check("R3", "slot 3", v, VECS[k].exp_l3);
            check("R7", "err_stack", {31'd0, err_stack}, {31'd0, VECS[k].exp_stk});
            check("R8", "err_opcode", {31'd0, err_opcode}, {31'd0, VECS[k].exp_op});
        end

        // R9: cycle count of the sample program; R11 debug reads
        load_prog(VECS[0].prog);
        run(edges);
        check("R9", "edges to done", edges, 32'd25);
        peek(2'd1, v);
        check("R11", "slot 1", v, 32'd15);
        peek(2'd2, v);
        check("R11", "slot 2", v, 32'd9);
        peek(2'd0, v);
        check("R11", "slot 0 untouched", v, 32'd0);
        // R1: final address = 13 bytes consumed (two operand fetches)
        check("R1", "code_addr at done", {24'd0, code_addr}, 32'd13);

        // R6: done and address hold while idle
        repeat (5) @(negedge clk);
        check("R6", "done held", {31'd0, done}, 32'd1);
        check("R6", "code_addr held", {24'd0, code_addr}, 32'd13);

        // R7: fault leaves locals untouched (slot 1 = 5, slot 2 stays 0)
        load_prog(128'h10053c3d3db100000000000000000000);
        run(edges);
        check("R7", "err_stack", {31'd0, err_stack}, 32'd1);
        peek(2'd1, v);
        check("R7", "slot 1 before fault", v, 32'd5);
        peek(2'd2, v);
        check("R7", "slot 2 not written", v, 32'd0);

        // R6: restart clears flags and locals
        load_prog(128'hb1000000000000000000000000000000);
        run(edges);
        check("R6", "err_stack cleared", {31'd0, err_stack}, 32'd0);
        peek(2'd1, v);
        check("R6", "slot 1 cleared", v, 32'd0);
        check("R9", "return-only edges", edges, 32'd3);

        // R8: opcode 0x00 is unsupported
        load_prog(128'h00b10000000000000000000000000000);
        run(edges);
        check("R8", "err_opcode on 0x00", {31'd0, err_opcode}, 32'd1);
        check("R8", "code_addr after bad op", {24'd0, code_addr}, 32'd1);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule